// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block decides which of two software-programmed address windows an incoming request falls into. Each window is described by a 4 KiB-aligned start address, a byte length and an enable bit, all written through a small register port. When a window is switched on, its start and length are copied into live copies, and from then on every request address is compared against the live copies of all enabled windows.

The result, registered one cycle after the request, says whether the address hit a window, which window it was, and the byte offset of the address from that window's start. Window 0 stands for a target inside the block's owner and window 1 for a target reached through an external port. Two select outputs name the chosen target. A request that lands in no enabled window is flagged as a miss. Routing the data, bus handshakes beyond a one-cycle request strobe, and configuration-header logic are handled elsewhere.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset both windows are disabled, every register reads zero, and rsp_valid, rsp_hit, rsp_miss, rsp_to_int and rsp_to_ext are 0.
- R2: Register address bit 4 selects the window (window w at w*0x10). Bits 3:0 select the register: 0x0 is the 64-bit start register, whose bits 11:0 always read 0; 0x8 is the 32-bit length register, which takes wdata[31:0]; 0xC is the enable register, which takes wdata[0] and reads back the live enable in bit 0.
- R3: A write of 1 to a disabled window's enable copies start and length into the live window. The window then hits every address from start to start+length-1 and no address outside that range.
- R4: A write of 0 to an enabled window's enable removes it, so that its addresses miss.
- R5: A write to enable whose bit 0 equals the current enable has no effect. In particular, the live window keeps its old start and length.
- R6: Writes to start or length while a window is enabled change only the read-back value, not the live window.
- R7: When both enabled windows contain the address, window 0 is reported.
- R8: A request that matches no enabled window gives rsp_miss=1 and rsp_hit=0. Outside a response, hit and miss are both 0, and they are never both 1.
- R9: rsp_valid is 1 exactly one cycle after req_valid. On a hit, rsp_offset equals the request address minus the window's live start.
- R10: An enabled window whose live length is zero never hits.
- R11: On a hit in window 0 rsp_to_int=1, and on a hit in window 1 rsp_to_ext=1. At most one of them is set, and only with rsp_hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Register write byte address |
| reg_wdata | input | 64 | Register write data |
| reg_raddr | input | 5 | Register read byte address |
| reg_rdata | output | 64 | Register read data (combinational) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_hit | output | 1 | Address inside an enabled window |
| rsp_miss | output | 1 | Address inside no enabled window |
| rsp_win | output | 1 | Index of the matched window |
| rsp_offset | output | 64 | Address minus matched window start |
| rsp_to_int | output | 1 | Internal target selected (window 0) |
| rsp_to_ext | output | 1 | External target selected (window 1) |

## Verification
A table of addresses probes each window at its first and last byte and one byte beyond each end. This separates an off-by-one in the upper or lower bound from a correct compare, and shows that the offset is taken from the right start. Directed sequences then rewrite start and length under an enabled window, repeat same-value enable writes, and toggle enable off and on. These show whether the live window is copied only on a real rising enable. Overlapping windows, a zero-length window and idle cycles between requests separate the priority, empty-window and response-timing behaviour from the plain compare.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;

    localparam int ADDR_W     = 64;
    localparam int LEN_W      = 32;
    localparam int ALIGN_BITS = 12;
    localparam int GRP_BITS   = 4;   // 16-byte register group per window

    typedef enum logic [GRP_BITS-1:0] {
        REG_START = 4'h0,
        REG_LEN   = 4'h8,
        REG_EN    = 4'hC
    } reg_ofs_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] start;
        logic [LEN_W-1:0]  len;
    } win_live_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] offset;
    } win_match_t;

    function automatic win_match_t match_window(win_live_t w, logic [ADDR_W-1:0] a);
        win_match_t        m;
        logic [ADDR_W-1:0] diff;
        diff     = a - w.start;
        m.offset = diff;
        m.hit    = w.en && (w.len != '0) && (a >= w.start)
                   && (diff < {{(ADDR_W-LEN_W){1'b0}}, w.len});
        return m;
    endfunction

endpackage

// File: rtl/win_regs.sv
module win_regs
    import win_dec_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int REG_AW  = $clog2(NUM_WIN) + GRP_BITS
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [63:0]       rd_data,
    output win_live_t         live_o [NUM_WIN]
);
    localparam int IDX_W = REG_AW - GRP_BITS;

    logic [ADDR_W-1:0] rb_start [NUM_WIN];
    logic [LEN_W-1:0]  rb_len   [NUM_WIN];
    logic              rb_en    [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [ADDR_W-1:ALIGN_BITS] start_q;
        logic [LEN_W-1:0]           len_q;
        win_live_t                  live_q;
        logic                       sel;

        assign sel = wr_en && (wr_addr[REG_AW-1:GRP_BITS] == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                start_q <= '0;
                len_q   <= '0;
                live_q  <= '0;
            end else if (sel) begin
                case (wr_addr[GRP_BITS-1:0])
                    REG_START: start_q <= wr_data[ADDR_W-1:ALIGN_BITS];
                    REG_LEN:   len_q   <= wr_data[LEN_W-1:0];
                    REG_EN: begin
                        if (wr_data[0] != live_q.en) begin
                            live_q.en <= wr_data[0];
                            if (wr_data[0]) begin
                                live_q.start <= {start_q, {ALIGN_BITS{1'b0}}};
                                live_q.len   <= len_q;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end

        assign live_o[g]   = live_q;
        assign rb_start[g] = {start_q, {ALIGN_BITS{1'b0}}};
        assign rb_len[g]   = len_q;
        assign rb_en[g]    = live_q.en;
    end

    always_comb begin
        logic [IDX_W-1:0] ridx;
        ridx = rd_addr[REG_AW-1:GRP_BITS];
        case (rd_addr[GRP_BITS-1:0])
            REG_START: rd_data = rb_start[ridx];
            REG_LEN:   rd_data = {{(64-LEN_W){1'b0}}, rb_len[ridx]};
            REG_EN:    rd_data = {63'b0, rb_en[ridx]};
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/win_match.sv
module win_match
    import win_dec_pkg::*;
(
    input  win_live_t         live_i,
    input  logic [ADDR_W-1:0] addr_i,
    output win_match_t        match_o
);
    assign match_o = match_window(live_i, addr_i);
endmodule

// File: rtl/win_select.sv
module win_select
    import win_dec_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = $clog2(NUM_WIN)
)(
    input  win_match_t        match_i [NUM_WIN],
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] offset_o
);
    // Lowest index wins: scan downward so the last assignment is the lowest hit.
    always_comb begin
        any_o    = 1'b0;
        idx_o    = '0;
        offset_o = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match_i[i].hit) begin
                any_o    = 1'b1;
                idx_o    = IDX_W'(i);
                offset_o = match_i[i].offset;
            end
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import win_dec_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = $clog2(NUM_WIN),
    parameter int REG_AW  = IDX_W + GRP_BITS
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_waddr,
    input  logic [63:0]       reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [63:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic              rsp_to_int,
    output logic              rsp_to_ext
);
    win_live_t         live  [NUM_WIN];
    win_match_t        match [NUM_WIN];
    logic              any_hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [ADDR_W-1:0] hit_off;

    win_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_addr (reg_waddr),
        .wr_data (reg_wdata),
        .rd_addr (reg_raddr),
        .rd_data (reg_rdata),
        .live_o  (live)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        win_match u_match (
            .live_i  (live[g]),
            .addr_i  (req_addr),
            .match_o (match[g])
        );
    end

    win_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
        .match_i  (match),
        .any_o    (any_hit),
        .idx_o    (hit_idx),
        .offset_o (hit_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_win    <= '0;
            rsp_offset <= '0;
            rsp_to_int <= 1'b0;
            rsp_to_ext <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= req_valid && any_hit;
            rsp_miss   <= req_valid && !any_hit;
            rsp_win    <= hit_idx;
            rsp_offset <= hit_off;
            rsp_to_int <= req_valid && any_hit && (hit_idx == '0);
            rsp_to_ext <= req_valid && any_hit && (hit_idx != '0);
        end
    end

endmodule

// File: rtl/win_dec_checker.sv
module win_dec_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_miss,
    input logic rsp_to_int,
    input logic rsp_to_ext
);
    a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r9_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r8_hit_miss_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_miss));
    a_r8_outcome_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit || rsp_miss) |-> rsp_valid);
    a_r8_valid_has_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit || rsp_miss));
    a_r11_target_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_to_int, rsp_to_ext}));
    a_r11_target_needs_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> $onehot({rsp_to_int, rsp_to_ext}));
endmodule

bind addr_window_decoder win_dec_checker u_win_dec_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_to_int (rsp_to_int),
    .rsp_to_ext (rsp_to_ext)
);

// File: tb/addr_window_decoder_bench.sv
`timescale 1ns/1ps
module addr_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_waddr = '0;
    logic [63:0] reg_wdata = '0;
    logic [4:0]  reg_raddr = '0;
    logic [63:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_to_int, rsp_to_ext;
    logic [0:0]  rsp_win;
    logic [63:0] rsp_offset;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    addr_window_decoder u_addr_window_decoder (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_offset(rsp_offset),
        .rsp_to_int(rsp_to_int), .rsp_to_ext(rsp_to_ext)
    );

    // Address table with windows: w0 = 0x8_0000_0000 + 0x10000, w1 = 0x8_2000_0000 + 0x4000
    localparam int NV = 8;
    localparam logic [63:0] V_ADDR [NV] = '{
        64'h8_0000_0000, 64'h8_0000_FFFF, 64'h8_0001_0000, 64'h7_FFFF_FFFF,
        64'h8_2000_0000, 64'h8_2000_3FFF, 64'h8_2000_4000, 64'h0
    };
    localparam logic V_HIT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic V_WIN [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic [63:0] V_OFF [NV] = '{
        64'h0, 64'hFFFF, 64'h0, 64'h0, 64'h0, 64'h3FFF, 64'h0, 64'h0
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [4:0] a, input logic [63:0] exp);
        reg_raddr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic req(input string tag, input logic [63:0] a, input logic hit,
                       input logic win, input logic [63:0] off);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, {63'b0, rsp_valid}, 64'd1);
        chk({tag, " hit"},   {63'b0, rsp_hit},   {63'b0, hit});
        chk({tag, " miss"},  {63'b0, rsp_miss},  {63'b0, !hit});
        chk({tag, " R11 int"}, {63'b0, rsp_to_int}, {63'b0, hit && !win});
        chk({tag, " R11 ext"}, {63'b0, rsp_to_ext}, {63'b0, hit && win});
        if (hit) begin
            chk({tag, " win"}, {63'b0, rsp_win}, {63'b0, win});
            chk({tag, " R9 offset"}, rsp_offset, off);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < 2; w++) begin
            rd("R1 start", 5'(w*16 + 0),  64'h0);
            rd("R1 len",   5'(w*16 + 8),  64'h0);
            rd("R1 en",    5'(w*16 + 12), 64'h0);
        end
        chk("R1 rsp_valid", {63'b0, rsp_valid}, 64'd0);
        chk("R1 rsp_hit",   {63'b0, rsp_hit},   64'd0);
        chk("R1 rsp_miss",  {63'b0, rsp_miss},  64'd0);
        chk("R1 to_int",    {63'b0, rsp_to_int}, 64'd0);
        chk("R1 to_ext",    {63'b0, rsp_to_ext}, 64'd0);

        // R2: program window 0, low start bits read back as zero
        wr(5'h00, 64'h8_0000_0123);
        wr(5'h08, 64'hFFFF_FFFF_0001_0000);
        wr(5'h0C, 64'h1);
        rd("R2 start low bits", 5'h00, 64'h8_0000_0000);
        rd("R2 len 32-bit",     5'h08, 64'h0001_0000);
        rd("R2 en",             5'h0C, 64'h1);
        // window 1 at stride 0x10
        wr(5'h10, 64'h8_2000_0000);
        wr(5'h18, 64'h4000);
        wr(5'h1C, 64'h1);
        rd("R2 w1 start", 5'h10, 64'h8_2000_0000);

        // R3: table of boundary addresses
        for (int i = 0; i < NV; i++)
            req($sformatf("R3 vec%0d", i), V_ADDR[i], V_HIT[i], V_WIN[i], V_OFF[i]);

        // R9: no response on an idle cycle
        @(negedge clk);
        chk("R9 idle valid", {63'b0, rsp_valid}, 64'd0);
        chk("R8 idle miss",  {63'b0, rsp_miss},  64'd0);

        // R6: writes under an enabled window do not move it
        wr(5'h00, 64'h9_0000_0000);
        wr(5'h08, 64'h20);
        rd("R6 start readback", 5'h00, 64'h9_0000_0000);
        req("R6 old window", 64'h8_0000_8000, 1'b1, 1'b0, 64'h8000);
        req("R6 new start", 64'h9_0000_0000, 1'b0, 1'b0, 64'h0);

        // R5: same-value enable write does not re-latch
        wr(5'h0C, 64'h1);
        req("R5 no relatch", 64'h8_0000_8000, 1'b1, 1'b0, 64'h8000);

        // R4 then R3: off and on re-latches
        wr(5'h0C, 64'h0);
        rd("R4 en readback", 5'h0C, 64'h0);
        req("R4 removed", 64'h8_0000_0000, 1'b0, 1'b0, 64'h0);
        wr(5'h0C, 64'h1);
        req("R3 relatch last", 64'h9_0000_001F, 1'b1, 1'b0, 64'h1F);
        req("R3 relatch past", 64'h9_0000_0020, 1'b0, 1'b0, 64'h0);

        // R4 on window 1, R5 repeated zero
        wr(5'h1C, 64'h0);
        req("R4 w1 removed", 64'h8_2000_0000, 1'b0, 1'b0, 64'h0);
        wr(5'h1C, 64'h0);
        rd("R5 en stays 0", 5'h1C, 64'h0);
        req("R5 w1 still off", 64'h8_2000_0000, 1'b0, 1'b0, 64'h0);

        // R7: overlap, window 0 wins
        wr(5'h10, 64'h9_0000_0000);
        wr(5'h1C, 64'h1);
        req("R7 overlap w0", 64'h9_0000_0010, 1'b1, 1'b0, 64'h10);
        req("R7 only w1",    64'h9_0000_0100, 1'b1, 1'b1, 64'h100);

        // R10: zero-length window never hits
        wr(5'h1C, 64'h0);
        wr(5'h0C, 64'h0);
        wr(5'h08, 64'h0);
        wr(5'h0C, 64'h1);
        rd("R10 en set", 5'h0C, 64'h1);
        req("R10 zero len", 64'h9_0000_0000, 1'b0, 1'b0, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule